// File: doc/BRIEF.md
# Three-Wire Register Access Port

This block is a slave serial port that lets a host read and write a bank of sixteen 12-bit registers over three control pins and one shared data pin. The host frames each access by pulling the active-low select line down, clocks 16 bits with its own serial clock, and uses a direction pin to decide whether the shared data pin carries bits into the port or out of it. The first bits of a frame form the register address. The remaining bits are the payload.

All four host pins are resynchronised into the block's system clock domain, so the serial clock must be several system clocks slower than the system clock. On a write, the payload is collected and stored in the addressed register only once the frame is complete. On a read, the host raises the direction pin after the address. The port then presents the addressed word, least significant bit first, on a data-out signal together with an output-enable signal. The pad buffer that joins these two signals to the shared pin lies outside the block.

Top module: `twr_port`

## Requirements
- R1: After a synchronous reset every register reads back as 0x000, and `sdio_oe` is low.
- R2: A frame is sampled on rising `sclk` edges while `sel_n` is low. The first four bits form the address, least significant bit first. The next twelve bits form the payload, bit 0 first.
- R3: When `rw` is low at the 16th rising edge of a frame, the payload is written to the addressed register. Every one of the sixteen addresses holds its own word.
- R4: On a read, bit 0 of the addressed register is on `sdio_out` once the address is complete. Each later bit replaces it after one falling `sclk` edge, so the host collects bits 0 to 11 on rising edges 5 to 16. A read leaves the register unchanged.
- R5: `sdio_oe` is high only while `sel_n` is low and `rw` is high. When `sel_n` is high, `sdio_oe` is low whatever the level of `rw`.
- R6: A frame that `sel_n` ends before its 16th rising edge writes nothing.
- R7: The bit position returns to the first address bit whenever `sel_n` is high, so a frame that follows an aborted one is decoded from its own first bit.
- R8: A rising `sclk` edge that reaches the port in the same system cycle as the rise of `sel_n` is ignored.
- R9: Rising edges after the 16th in one frame are ignored and cause no second write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host serial clock, asynchronous to `clk` |
| sel_n | input | 1 | Active-low frame select |
| rw | input | 1 | Direction: low means host to port, high means port to host |
| sdio_in | input | 1 | Value seen on the shared data pin |
| sdio_out | output | 1 | Read data bit driven towards the shared pin |
| sdio_oe | output | 1 | Output enable for the shared pin driver |

## Verification
The 16th rising edge of `sclk` can land in the same system cycle as the release of the frame. In that cycle the write commit and the frame reset both want to act. The bench provokes this by raising `sclk` and `sel_n` in the same time step, so that the two identical synchronisers deliver both changes together. The case is judged by reading the register back and finding its old contents (R8). The same read-back method judges aborted frames, overrun clocks and the exhaustive write-then-read sweep over all sixteen addresses.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 12;
    localparam int NREG        = 1 << ADDR_W;
    localparam int FRAME_BITS  = ADDR_W + DATA_W;
    localparam int CNT_W       = $clog2(FRAME_BITS + 1);
    localparam int SYNC_STAGES = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Host pins as one bundle so they travel through one synchroniser.
    typedef struct packed {
        logic sclk;
        logic sel_n;
        logic rw;
        logic din;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, sel_n: 1'b1, rw: 1'b0, din: 1'b0};

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_DATA,
        PH_DONE
    } phase_e;

    function automatic phase_e phase_of(cnt_t c);
        if (c < cnt_t'(ADDR_W))
            return PH_ADDR;
        else if (c < cnt_t'(FRAME_BITS))
            return PH_DATA;
        else
            return PH_DONE;
    endfunction

    function automatic word_t word_shift_in(word_t cur, logic b);
        return {b, cur[DATA_W-1:1]};
    endfunction

    function automatic addr_t addr_shift_in(addr_t cur, logic b);
        return {b, cur[ADDR_W-1:1]};
    endfunction

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk) begin
            if (rst)
                ff <= {STAGES{RST_VAL[i]}};
            else
                ff <= {ff[STAGES-2:0], d[i]};
        end
        assign q[i] = ff[STAGES-1];
    end

endmodule

// File: rtl/twr_edge.sv
module twr_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic level_d;

    always_ff @(posedge clk) begin
        if (rst)
            level_d <= 1'b0;
        else
            level_d <= level;
    end

    assign rise = level & ~level_d;
    assign fall = ~level & level_d;

endmodule

// File: rtl/twr_frame.sv
module twr_frame
    import twr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  desel,
    input  logic  rise,
    input  logic  rw_s,
    input  logic  din_s,
    output cnt_t  cnt,
    output logic  load,
    output addr_t rd_addr,
    output logic  wr_en,
    output addr_t wr_addr,
    output word_t wr_data
);

    addr_t  addr_q;
    word_t  data_q;
    phase_e ph;
    logic   take;

    assign ph   = phase_of(cnt);
    assign take = rise && !desel && (ph != PH_DONE);

    always_ff @(posedge clk) begin
        if (rst || desel) begin
            cnt    <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            cnt <= cnt + cnt_t'(1);
            if (ph == PH_ADDR)
                addr_q <= addr_shift_in(addr_q, din_s);
            else
                data_q <= word_shift_in(data_q, din_s);
        end
    end

    // Address completes on the last address bit; the read word is fetched then.
    assign load    = take && (cnt == cnt_t'(ADDR_W - 1));
    assign rd_addr = addr_shift_in(addr_q, din_s);

    assign wr_en   = take && (cnt == cnt_t'(FRAME_BITS - 1)) && !rw_s;
    assign wr_addr = addr_q;
    assign wr_data = word_shift_in(data_q, din_s);

endmodule

// File: rtl/twr_bank.sv
module twr_bank
    import twr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  word_t wr_data,
    input  addr_t rd_addr,
    output word_t rd_data
);

    word_t regs [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[r] <= '0;
            else if (wr_en && (wr_addr == addr_t'(r)))
                regs[r] <= wr_data;
        end
    end

    assign rd_data = regs[rd_addr];

endmodule

// File: rtl/twr_txshift.sv
module twr_txshift
    import twr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  desel,
    input  logic  load,
    input  logic  fall,
    input  cnt_t  cnt,
    input  word_t rd_data,
    output logic  bit_out
);

    word_t sh;
    logic  adv;

    // Advance after the falls that follow payload rises 5..15.
    assign adv = fall && (cnt > cnt_t'(ADDR_W)) && (cnt < cnt_t'(FRAME_BITS));

    always_ff @(posedge clk) begin
        if (rst || desel)
            sh <= '0;
        else if (load)
            sh <= rd_data;
        else if (adv)
            sh <= word_shift_in(sh, 1'b0);
    end

    assign bit_out = sh[0];

endmodule

// File: rtl/twr_port.sv
module twr_port
    import twr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sel_n,
    input  logic rw,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe
);

    pins_t raw;
    pins_t syn;
    logic  desel;
    logic  rise;
    logic  fall;
    cnt_t  cnt;
    logic  load;
    addr_t rd_addr;
    word_t rd_data;
    logic  wr_en;
    addr_t wr_addr;
    word_t wr_data;
    logic  oe_q;

    assign raw = '{sclk: sclk, sel_n: sel_n, rw: rw, din: sdio_in};

    twr_sync #(
        .W       ($bits(pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    assign desel = syn.sel_n;

    twr_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (syn.sclk),
        .rise  (rise),
        .fall  (fall)
    );

    twr_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .desel   (desel),
        .rise    (rise),
        .rw_s    (syn.rw),
        .din_s   (syn.din),
        .cnt     (cnt),
        .load    (load),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    twr_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    twr_txshift u_tx (
        .clk     (clk),
        .rst     (rst),
        .desel   (desel),
        .load    (load),
        .fall    (fall),
        .cnt     (cnt),
        .rd_data (rd_data),
        .bit_out (sdio_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            oe_q <= 1'b0;
        else
            oe_q <= !desel && syn.rw;
    end

    assign sdio_oe = oe_q;

endmodule

// File: rtl/twr_port_chk.sv
module twr_port_chk
    import twr_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic desel,
    input logic rise,
    input logic fall,
    input logic load,
    input logic wr_en,
    input cnt_t cnt,
    input logic sdio_out,
    input logic sdio_oe
);

    a_r5_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
        desel |=> !sdio_oe);

    a_r7_count_cleared: assert property (@(posedge clk) disable iff (rst)
        desel |=> (cnt == '0));

    a_r8_edge_at_release: assert property (@(posedge clk) disable iff (rst)
        (rise && desel) |=> (cnt == '0) && !sdio_oe);

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= cnt_t'(FRAME_BITS));

    a_r3_commit_ends_frame: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == cnt_t'(FRAME_BITS)));

    a_r4_out_holds: assert property (@(posedge clk) disable iff (rst)
        (!fall && !load && !desel) |=> $stable(sdio_out));

endmodule

bind twr_port twr_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .desel    (desel),
    .rise     (rise),
    .fall     (fall),
    .load     (load),
    .wr_en    (wr_en),
    .cnt      (cnt),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe)
);

// File: tb/twr_port_test.sv
module twr_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic sel_n = 1'b1;
    logic rw = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out;
    logic sdio_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twr_port uut (
        .clk      (clk),
        .rst      (rst),
        .sclk     (sclk),
        .sel_n    (sel_n),
        .rw       (rw),
        .sdio_in  (sdio_in),
        .sdio_out (sdio_out),
        .sdio_oe  (sdio_oe)
    );

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] pat(int a, int k);
        return 12'((a * 12'h1A7 + k * 12'h2C9 + 12'h035) ^ (a << 7));
    endfunction

    task automatic send_bit(logic b);
        sdio_in = b;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_addr(logic [3:0] a);
        for (int i = 0; i < 4; i++) send_bit(a[i]);
    endtask

    task automatic end_frame();
        wait_clk(HALF);
        rw = 1'b0;
        sel_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic do_write(logic [3:0] a, logic [11:0] d);
        sel_n = 1'b0;
        rw = 1'b0;
        wait_clk(HALF);
        send_addr(a);
        for (int i = 0; i < 12; i++) send_bit(d[i]);
        end_frame();
    endtask

    // Sends only the first nbits of a write frame, then deselects.
    task automatic partial_write(logic [3:0] a, logic [11:0] d, int nbits);
        logic [15:0] fr;
        fr = {d, a};
        sel_n = 1'b0;
        rw = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) send_bit(fr[i]);
        end_frame();
    endtask

    task automatic do_read(logic [3:0] a, output logic [11:0] q, output logic oe_all);
        sel_n = 1'b0;
        rw = 1'b0;
        wait_clk(HALF);
        send_addr(a);
        rw = 1'b1;
        oe_all = 1'b1;
        for (int i = 0; i < 12; i++) begin
            wait_clk(HALF);
            q[i] = sdio_out;
            if (sdio_oe !== 1'b1) oe_all = 1'b0;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        end_frame();
    endtask

    task automatic read_check(string req, logic [3:0] a, logic [11:0] exp);
        logic [11:0] q;
        logic oe_all;
        do_read(a, q, oe_all);
        check(req, {20'd0, q}, {20'd0, exp});
        check("R5 oe during read", {31'd0, oe_all}, 32'd1);
    endtask

    logic [11:0] model [16];

    initial begin
        logic [11:0] fr_d;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);

        // R1: reset state
        check("R1 oe after reset", {31'd0, sdio_oe}, 32'd0);
        for (int a = 0; a < 16; a++) begin
            model[a] = 12'h000;
            read_check("R1 reset readback", 4'(a), 12'h000);
        end

        // R5: deselected with rw high must not drive
        rw = 1'b1;
        wait_clk(HALF);
        check("R5 no drive when sel_n high", {31'd0, sdio_oe}, 32'd0);
        rw = 1'b0;
        wait_clk(HALF);

        // R2/R3/R4: exhaustive sweep over addresses, two data passes
        for (int k = 1; k <= 2; k++) begin
            for (int a = 0; a < 16; a++) begin
                model[a] = pat(a, k);
                do_write(4'(a), model[a]);
            end
            for (int a = 15; a >= 0; a--)
                read_check("R3 sweep readback", 4'(a), model[a]);
        end

        // R2: extreme payloads, walking one in bit order
        model[5] = 12'hFFF; do_write(4'd5, 12'hFFF);
        read_check("R2 all ones", 4'd5, 12'hFFF);
        model[10] = 12'h000; do_write(4'd10, 12'h000);
        read_check("R2 all zeros", 4'd10, 12'h000);
        for (int b = 0; b < 12; b++) begin
            model[9] = 12'(1) << b;
            do_write(4'd9, model[9]);
            read_check("R2 walking one", 4'd9, model[9]);
        end

        // R4: read leaves register unchanged
        read_check("R4 second read", 4'd9, model[9]);
        read_check("R4 neighbour intact", 4'd5, model[5]);

        // R6: aborted frames write nothing
        for (int n = 1; n <= 15; n += 7) begin
            partial_write(4'd3, ~model[3], n);
            read_check("R6 aborted frame", 4'd3, model[3]);
        end
        partial_write(4'd3, 12'hABC, 15);
        read_check("R6 aborted at bit 15", 4'd3, model[3]);

        // R7: frame after an abort decodes from its own first bit
        partial_write(4'd6, 12'h5A5, 3);
        model[12] = 12'h3C7;
        do_write(4'd12, 12'h3C7);
        read_check("R7 fresh frame target", 4'd12, 12'h3C7);
        read_check("R7 aborted target intact", 4'd6, model[6]);

        // R8: 16th rise together with release of select
        fr_d = ~model[7];
        sel_n = 1'b0;
        rw = 1'b0;
        wait_clk(HALF);
        send_addr(4'd7);
        for (int i = 0; i < 11; i++) send_bit(fr_d[i]);
        sdio_in = fr_d[11];
        wait_clk(HALF);
        sclk = 1'b1;
        sel_n = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(HALF);
        read_check("R8 collided edge ignored", 4'd7, model[7]);

        // R9: extra clocks after the 16th cause no second write
        model[11] = 12'h6D2;
        sel_n = 1'b0;
        rw = 1'b0;
        wait_clk(HALF);
        send_addr(4'd11);
        for (int i = 0; i < 12; i++) send_bit(model[11][i]);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        end_frame();
        read_check("R9 overrun ignored", 4'd11, model[11]);
        read_check("R9 other address intact", 4'd15, model[15]);

        check("R5 oe idle at end", {31'd0, sdio_oe}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule